// File: doc/BRIEF.md
# Low-Power SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a low-power synchronous DRAM. It takes the memory from power-on to an idle, programmed state. While reset is held it deselects the device and keeps clock enable and the data mask high. After reset it drives no-operation commands for a start-up pause given in microseconds and converted to clock cycles by parameter. It then precharges every bank and loads the standard mode register and the extended mode register from static configuration inputs. It also issues a programmable number of auto-refresh commands, either before or after the two register loads, with a programmable idle gap after each command. When the last gap has elapsed it raises a sticky `init_done`. From then on it keeps driving no-operation and releases the data mask, so the normal controller can take over the pins.

The configuration inputs are plain control levels and are not handshaked. They are sampled in the cycle the sequencer decides to issue the corresponding register load. They must be stable from reset release until `init_done`. The command, bank and address outputs all come straight from registers.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While rst_n is low the pins show deselect ({cs_n,ras_n,cas_n,we_n} = 1111), cke = 1, dqm = 1, ba = 0, addr = 0 and init_done = 0.
- R2: For exactly CLK_MHZ*PAUSE_US cycles after reset release the pins show no-operation (0111), with cke and dqm high.
- R3: The cycle after the pause carries precharge-all: command 0010, ba = 00, addr bit 10 = 1 and every other address bit 0.
- R4: Exactly T_RP no-operation cycles follow the precharge before the next command.
- R5: The standard register load is command 0000 with ba = 00 and addr = {zeros, single_write at bit 9, 00 at bits 8:7, cas code at bits 6:4, interleave at bit 3, burst code at bits 2:0}.
- R6: The extended register load is command 0000 with ba = 10 (ba[1] = 1, ba[0] = 0) and addr = {zeros, refresh-rate code at bits 4:3, partial-array code at bits 2:0}. Bits 5 and up are 0, and it directly follows the standard load's gap.
- R7: Each register load is followed by exactly T_MRD (at least 1) no-operation cycles before the next command.
- R8: N_REFRESH (at least 8) auto-refresh commands (0001, ba = 0, addr = 0) are issued, each followed by exactly T_RC no-operation cycles.
- R9: With REFRESH_FIRST = 0 the refreshes come after both register loads. With REFRESH_FIRST = 1 they come between the precharge gap and the standard load.
- R10: cke is high in every cycle, and in particular in the cycle before any register load.
- R11: init_done rises in the first cycle after the final gap and stays high. From then on the pins show no-operation with dqm low.
- R12: The only commands ever driven are deselect, no-operation, precharge, register load and auto-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also running to the memory |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bl_code | input | 3 | Burst length code for the standard register |
| cfg_interleave | input | 1 | 1 selects interleaved burst order |
| cfg_cas_code | input | 3 | CAS latency code |
| cfg_single_write | input | 1 | 1 selects burst read with single write |
| cfg_pasr | input | 3 | Partial-array self-refresh code |
| cfg_tcr | input | 2 | Self-refresh rate code for case temperature |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | 1 | Data mask |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | ADDR_W | Row/column address bus |
| init_done | output | 1 | Sticky initialization-complete flag |

## Verification
The bench runs two instances side by side. One uses the default ordering. The other orders refreshes first, uses a one-cycle load gap, a one-cycle precharge gap and nine refreshes, so a design that puts loads back to back, stops the refresh count at a fixed eight, or ignores the ordering choice drifts out of step within a cycle. A second pass after re-reset drives every configuration field with a different, mostly all-ones pattern, which exposes a field placed at the wrong bit or upper bits of the extended word left non-zero. Every cycle is compared against a per-cycle expected schedule, so a done flag raised one cycle early or a pause one cycle short fails on the cycle where it happens.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Sequencer phases; each command phase lasts exactly one cycle.
  typedef enum logic [2:0] {
    PH_PAUSE    = 3'd0,
    PH_PRECH    = 3'd1,
    PH_GAP      = 3'd2,
    PH_LOAD_STD = 3'd3,
    PH_LOAD_EXT = 3'd4,
    PH_REFRESH  = 3'd5,
    PH_READY    = 3'd6
  } phase_e;

  // Most recent command, used to choose the phase after a gap.
  typedef enum logic [1:0] {
    LAST_PRECH = 2'd0,
    LAST_LSTD  = 2'd1,
    LAST_LEXT  = 2'd2,
    LAST_AREF  = 2'd3
  } last_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PIN_DESEL = 4'b1111;
  localparam logic [3:0] PIN_NOP   = 4'b0111;
  localparam logic [3:0] PIN_PRECH = 4'b0010;
  localparam logic [3:0] PIN_LOAD  = 4'b0000;
  localparam logic [3:0] PIN_AREF  = 4'b0001;

  localparam logic [1:0] BA_STD = 2'b00;
  localparam logic [1:0] BA_EXT = 2'b10;

  localparam int PRECH_ALL_BIT = 10;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int W       = 16,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= W'(RST_VAL);
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R4/R7/R8: an expired gap timer stays expired until reloaded
  p_timer_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);

  // R2: while counting and not reloaded the timer moves by exactly one
  p_timer_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdram_mode_words.sv
module sdram_mode_words #(
  parameter int ADDR_W = 13
) (
  input  logic [2:0]        cfg_bl_code,
  input  logic              cfg_interleave,
  input  logic [2:0]        cfg_cas_code,
  input  logic              cfg_single_write,
  input  logic [2:0]        cfg_pasr,
  input  logic [1:0]        cfg_tcr,
  output logic [ADDR_W-1:0] std_word,
  output logic [ADDR_W-1:0] ext_word
);

  localparam int STD_BITS = 10;
  localparam int EXT_BITS = 5;

  logic [STD_BITS-1:0] std_low;
  logic [EXT_BITS-1:0] ext_low;

  // Field positions are decoded by the memory and must stay fixed.
  assign std_low = {cfg_single_write, 2'b00, cfg_cas_code, cfg_interleave, cfg_bl_code};
  assign ext_low = {cfg_tcr, cfg_pasr};

  assign std_word = ADDR_W'(std_low);
  assign ext_word = ADDR_W'(ext_low);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int T_RP          = 3,
  parameter int T_RC          = 10,
  parameter int T_MRD         = 2,
  parameter int N_REFRESH     = 8,
  parameter int REFRESH_FIRST = 0,
  parameter int TIMER_W       = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tmr_zero,
  output logic               tmr_load,
  output logic [TIMER_W-1:0] tmr_val,
  output phase_e             phase
);

  localparam int RC_W = $clog2(N_REFRESH + 1);

  phase_e           phase_q, phase_d, follow;
  last_e            last_q;
  logic [RC_W-1:0]  ref_cnt_q;

  // Phase after a gap, from the last command and the refresh count.
  always_comb begin
    follow = PH_READY;
    case (last_q)
      LAST_PRECH: follow = (REFRESH_FIRST != 0) ? PH_REFRESH : PH_LOAD_STD;
      LAST_LSTD:  follow = PH_LOAD_EXT;
      LAST_LEXT:  follow = (REFRESH_FIRST != 0) ? PH_READY : PH_REFRESH;
      LAST_AREF: begin
        if (ref_cnt_q < RC_W'(N_REFRESH)) follow = PH_REFRESH;
        else follow = (REFRESH_FIRST != 0) ? PH_LOAD_STD : PH_READY;
      end
      default:    follow = PH_READY;
    endcase
  end

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (phase_q)
      PH_PAUSE: if (tmr_zero) phase_d = PH_PRECH;
      PH_PRECH: begin
        phase_d  = PH_GAP;
        tmr_load = 1'b1;
        tmr_val  = TIMER_W'(T_RP - 1);
      end
      PH_LOAD_STD, PH_LOAD_EXT: begin
        phase_d  = PH_GAP;
        tmr_load = 1'b1;
        tmr_val  = TIMER_W'(T_MRD - 1);
      end
      PH_REFRESH: begin
        phase_d  = PH_GAP;
        tmr_load = 1'b1;
        tmr_val  = TIMER_W'(T_RC - 1);
      end
      PH_GAP:   if (tmr_zero) phase_d = follow;
      PH_READY: phase_d = PH_READY;
      default:  phase_d = PH_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_PAUSE;
      last_q    <= LAST_PRECH;
      ref_cnt_q <= '0;
    end else begin
      phase_q <= phase_d;
      case (phase_q)
        PH_PRECH:    last_q <= LAST_PRECH;
        PH_LOAD_STD: last_q <= LAST_LSTD;
        PH_LOAD_EXT: last_q <= LAST_LEXT;
        PH_REFRESH: begin
          last_q    <= LAST_AREF;
          ref_cnt_q <= ref_cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign phase = phase_q;

  // R8: the refresh count never passes the configured number
  p_ref_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cnt_q <= RC_W'(N_REFRESH));

  // R9: refresh-first ordering loads the register only after all refreshes
  p_refresh_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((REFRESH_FIRST != 0) && phase_q == PH_LOAD_STD) |-> (ref_cnt_q == RC_W'(N_REFRESH)));

  // R9: default ordering refreshes only after the extended load
  p_loads_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((REFRESH_FIRST == 0) && phase_q == PH_REFRESH) |-> (last_q == LAST_LEXT || last_q == LAST_AREF));

  // R11: the ready phase is final
  p_ready_final_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_READY) |=> (phase_q == PH_READY));

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic [ADDR_W-1:0] std_word,
  input  logic [ADDR_W-1:0] ext_word,
  output logic [3:0]        pins_q,
  output logic [1:0]        ba_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              cke_q,
  output logic              dqm_q,
  output logic              done_q
);

  logic [3:0]        pins_d;
  logic [1:0]        ba_d;
  logic [ADDR_W-1:0] addr_d;
  logic              done_d;

  always_comb begin
    pins_d = PIN_NOP;
    ba_d   = 2'b00;
    addr_d = '0;
    done_d = 1'b0;
    case (phase)
      PH_PRECH: begin
        pins_d                = PIN_PRECH;
        addr_d[PRECH_ALL_BIT] = 1'b1;
      end
      PH_LOAD_STD: begin
        pins_d = PIN_LOAD;
        ba_d   = BA_STD;
        addr_d = std_word;
      end
      PH_LOAD_EXT: begin
        pins_d = PIN_LOAD;
        ba_d   = BA_EXT;
        addr_d = ext_word;
      end
      PH_REFRESH: pins_d = PIN_AREF;
      PH_READY:   done_d = 1'b1;
      default:    pins_d = PIN_NOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= PIN_DESEL;
      ba_q   <= 2'b00;
      addr_q <= '0;
      cke_q  <= 1'b1;
      dqm_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      pins_q <= pins_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
      cke_q  <= 1'b1;
      dqm_q  <= !done_d;
      done_q <= done_d;
    end
  end

  // R12: only the five permitted commands reach the pins
  p_legal_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_q == PIN_NOP || pins_q == PIN_PRECH || pins_q == PIN_LOAD ||
     pins_q == PIN_AREF || pins_q == PIN_DESEL));

  // R7: a register load is always followed by a no-operation cycle
  p_nop_after_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_q == PIN_LOAD) |=> (pins_q == PIN_NOP));

  // R10: clock enable was high the cycle before a register load
  p_cke_before_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_q == PIN_LOAD) |-> $past(cke_q));

  // R6: extended load leaves bits 5 and up clear
  p_ext_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_q == PIN_LOAD && ba_q == BA_EXT) |-> (addr_q[ADDR_W-1:5] == '0));

  // R3: precharge carries the all-banks bit
  p_prech_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_q == PIN_PRECH) |-> (addr_q[PRECH_ALL_BIT] && ba_q == 2'b00));

  // R11: done is sticky and quiet
  p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
  p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (pins_q == PIN_NOP && !dqm_q));

  // R2: data mask stays high until done
  p_dqm_until_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> dqm_q);

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int CLK_MHZ       = 100,
  parameter int PAUSE_US      = 200,
  parameter int T_RP          = 3,
  parameter int T_RC          = 10,
  parameter int T_MRD         = 2,
  parameter int N_REFRESH     = 8,
  parameter int REFRESH_FIRST = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_bl_code,
  input  logic              cfg_interleave,
  input  logic [2:0]        cfg_cas_code,
  input  logic              cfg_single_write,
  input  logic [2:0]        cfg_pasr,
  input  logic [1:0]        cfg_tcr,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_cke,
  output logic              sd_dqm,
  output logic [1:0]        sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done
);

  localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
  localparam int TIMER_W   = $clog2(max_of4(PAUSE_CYC, T_RP, T_RC, T_MRD) + 1);

  logic               tmr_load;
  logic [TIMER_W-1:0] tmr_val;
  logic               tmr_zero;
  phase_e             phase;
  logic [ADDR_W-1:0]  std_word;
  logic [ADDR_W-1:0]  ext_word;
  logic [3:0]         pins;

  sdram_init_timer #(
    .W       (TIMER_W),
    .RST_VAL (PAUSE_CYC - 1)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sdram_init_fsm #(
    .T_RP          (T_RP),
    .T_RC          (T_RC),
    .T_MRD         (T_MRD),
    .N_REFRESH     (N_REFRESH),
    .REFRESH_FIRST (REFRESH_FIRST),
    .TIMER_W       (TIMER_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .phase    (phase)
  );

  sdram_mode_words #(
    .ADDR_W (ADDR_W)
  ) u_words (
    .cfg_bl_code      (cfg_bl_code),
    .cfg_interleave   (cfg_interleave),
    .cfg_cas_code     (cfg_cas_code),
    .cfg_single_write (cfg_single_write),
    .cfg_pasr         (cfg_pasr),
    .cfg_tcr          (cfg_tcr),
    .std_word         (std_word),
    .ext_word         (ext_word)
  );

  sdram_cmd_drive #(
    .ADDR_W (ADDR_W)
  ) u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .std_word (std_word),
    .ext_word (ext_word),
    .pins_q   (pins),
    .ba_q     (sd_ba),
    .addr_q   (sd_addr),
    .cke_q    (sd_cke),
    .dqm_q    (sd_dqm),
    .done_q   (init_done)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins;

endmodule

// File: tb/sdram_pwrup_seq_tb.sv
module sdram_pwrup_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 13;
  localparam int EW         = AW + 8;
  localparam int PAUSE      = 40;

  // instance a: loads first
  localparam int A_TRP = 3, A_TRC = 5, A_TMRD = 2, A_NREF = 8;
  // instance b: refresh first, minimum gaps
  localparam int B_TRP = 1, B_TRC = 4, B_TMRD = 1, B_NREF = 9;

  localparam logic [3:0] C_DESEL = 4'b1111, C_NOP = 4'b0111, C_PRE = 4'b0010,
                         C_LOAD = 4'b0000, C_REF = 4'b0001;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n;
  logic [2:0] a_bl, a_cl, a_pasr, b_bl, b_cl, b_pasr;
  logic       a_il, a_sw, b_il, b_sw;
  logic [1:0] a_tcr, b_tcr;

  logic a_cs, a_ras, a_cas, a_we, a_cke, a_dqm, a_done;
  logic b_cs, b_ras, b_cas, b_we, b_cke, b_dqm, b_done;
  logic [1:0] a_ba, b_ba;
  logic [AW-1:0] a_addr, b_addr;

  sdram_pwrup_seq #(
    .ADDR_W(AW), .CLK_MHZ(1), .PAUSE_US(PAUSE), .T_RP(A_TRP), .T_RC(A_TRC),
    .T_MRD(A_TMRD), .N_REFRESH(A_NREF), .REFRESH_FIRST(0)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_bl_code(a_bl), .cfg_interleave(a_il),
    .cfg_cas_code(a_cl), .cfg_single_write(a_sw), .cfg_pasr(a_pasr), .cfg_tcr(a_tcr),
    .sd_cs_n(a_cs), .sd_ras_n(a_ras), .sd_cas_n(a_cas), .sd_we_n(a_we),
    .sd_cke(a_cke), .sd_dqm(a_dqm), .sd_ba(a_ba), .sd_addr(a_addr), .init_done(a_done)
  );

  sdram_pwrup_seq #(
    .ADDR_W(AW), .CLK_MHZ(1), .PAUSE_US(PAUSE), .T_RP(B_TRP), .T_RC(B_TRC),
    .T_MRD(B_TMRD), .N_REFRESH(B_NREF), .REFRESH_FIRST(1)
  ) dut_b (
    .clk(clk), .rst_n(rst_n), .cfg_bl_code(b_bl), .cfg_interleave(b_il),
    .cfg_cas_code(b_cl), .cfg_single_write(b_sw), .cfg_pasr(b_pasr), .cfg_tcr(b_tcr),
    .sd_cs_n(b_cs), .sd_ras_n(b_ras), .sd_cas_n(b_cas), .sd_we_n(b_we),
    .sd_cke(b_cke), .sd_dqm(b_dqm), .sd_ba(b_ba), .sd_addr(b_addr), .init_done(b_done)
  );

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;

  logic [EW-1:0] qa[$], qb[$];
  string         ta[$], tb[$];

  function automatic logic [EW-1:0] ent(input logic d, input logic m, input logic [3:0] c,
                                        input logic [1:0] ba, input logic [AW-1:0] a);
    return {d, m, c, ba, a};
  endfunction

  function automatic logic [AW-1:0] std_w(input logic [2:0] bl, input logic il,
                                          input logic [2:0] cl, input logic sw);
    return {3'b000, sw, 2'b00, cl, il, bl};
  endfunction

  function automatic logic [AW-1:0] ext_w(input logic [2:0] pasr, input logic [1:0] tcr);
    return {8'h00, tcr, pasr};
  endfunction

  task automatic add(input bit w, input logic [EW-1:0] v, input string t);
    if (!w) begin qa.push_back(v); ta.push_back(t); end
    else    begin qb.push_back(v); tb.push_back(t); end
  endtask

  task automatic add_nops(input bit w, input int n, input string t);
    for (int i = 0; i < n; i++) add(w, ent(1'b0, 1'b1, C_NOP, 2'b00, '0), t);
  endtask

  task automatic add_refs(input bit w, input int n, input int trc, input string t);
    for (int i = 0; i < n; i++) begin
      add(w, ent(1'b0, 1'b1, C_REF, 2'b00, '0), t);
      add_nops(w, trc, "R8");
    end
  endtask

  task automatic plan(input bit w, input bit rf, input int trp, input int tmrd,
                      input int trc, input int nref, input logic [2:0] bl, input logic il,
                      input logic [2:0] cl, input logic sw, input logic [2:0] pasr,
                      input logic [1:0] tcr);
    add_nops(w, PAUSE, "R2");
    add(w, ent(1'b0, 1'b1, C_PRE, 2'b00, 13'h0400), "R3");
    add_nops(w, trp, "R4");
    if (rf) add_refs(w, nref, trc, "R9");
    add(w, ent(1'b0, 1'b1, C_LOAD, 2'b00, std_w(bl, il, cl, sw)), "R5");
    add_nops(w, tmrd, "R7");
    add(w, ent(1'b0, 1'b1, C_LOAD, 2'b10, ext_w(pasr, tcr)), "R6");
    add_nops(w, tmrd, "R7");
    if (!rf) add_refs(w, nref, trc, "R8");
    for (int i = 0; i < 12; i++) add(w, ent(1'b1, 1'b0, C_NOP, 2'b00, '0), "R11");
  endtask

  task automatic chk(input string tag, input string who, input logic [EW-1:0] act,
                     input logic [EW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, who, act, exp);
    end
  endtask

  function automatic logic legal(input logic [3:0] c);
    return (c == C_NOP || c == C_PRE || c == C_LOAD || c == C_REF || c == C_DESEL);
  endfunction

  task automatic run_once();
    logic [EW-1:0] e;
    string t;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state on both instances
    chk("R1", "dut_i", {a_done, a_dqm, a_cs, a_ras, a_cas, a_we, a_ba, a_addr},
        ent(1'b0, 1'b1, C_DESEL, 2'b00, '0));
    chk("R1", "dut_b", {b_done, b_dqm, b_cs, b_ras, b_cas, b_we, b_ba, b_addr},
        ent(1'b0, 1'b1, C_DESEL, 2'b00, '0));
    chk("R1", "cke", EW'({a_cke, b_cke}), EW'(2'b11));
    rst_n = 1'b1;
    while (qa.size() != 0 || qb.size() != 0) begin
      @(posedge clk);
      @(negedge clk);
      if (qa.size() != 0) begin
        e = qa.pop_front();
        t = ta.pop_front();
        chk(t, "dut_i", {a_done, a_dqm, a_cs, a_ras, a_cas, a_we, a_ba, a_addr}, e);
        chk("R10", "dut_i", EW'(a_cke), EW'(1));
        chk("R12", "dut_i", EW'(legal({a_cs, a_ras, a_cas, a_we})), EW'(1));
      end
      if (qb.size() != 0) begin
        e = qb.pop_front();
        t = tb.pop_front();
        chk(t, "dut_b", {b_done, b_dqm, b_cs, b_ras, b_cas, b_we, b_ba, b_addr}, e);
        chk("R10", "dut_b", EW'(b_cke), EW'(1));
        chk("R12", "dut_b", EW'(legal({b_cs, b_ras, b_cas, b_we})), EW'(1));
      end
    end
  endtask

  initial begin
    rst_n = 1'b0;
    // pass 1: typical field values
    a_bl = 3'b011; a_il = 1'b0; a_cl = 3'b010; a_sw = 1'b0; a_pasr = 3'b000; a_tcr = 2'b01;
    b_bl = 3'b010; b_il = 1'b1; b_cl = 3'b011; b_sw = 1'b0; b_pasr = 3'b001; b_tcr = 2'b10;
    plan(1'b0, 1'b0, A_TRP, A_TMRD, A_TRC, A_NREF, a_bl, a_il, a_cl, a_sw, a_pasr, a_tcr);
    plan(1'b1, 1'b1, B_TRP, B_TMRD, B_TRC, B_NREF, b_bl, b_il, b_cl, b_sw, b_pasr, b_tcr);
    run_once();
    // pass 2: field-position stress after re-reset
    a_bl = 3'b111; a_il = 1'b1; a_cl = 3'b101; a_sw = 1'b1; a_pasr = 3'b101; a_tcr = 2'b11;
    b_bl = 3'b000; b_il = 1'b0; b_cl = 3'b111; b_sw = 1'b1; b_pasr = 3'b111; b_tcr = 2'b00;
    plan(1'b0, 1'b0, A_TRP, A_TMRD, A_TRC, A_NREF, a_bl, a_il, a_cl, a_sw, a_pasr, a_tcr);
    plan(1'b1, 1'b1, B_TRP, B_TMRD, B_TRC, B_NREF, b_bl, b_il, b_cl, b_sw, b_pasr, b_tcr);
    run_once();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R11: actual not finished expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule